// File: doc/BRIEF.md
# Edge-Staggered Loopback Pattern Checker

This block exercises an external signal path by sending a stored bit pattern out on one line and reading the returned signal back. Both directions share one timing clock. A new output state is driven when that clock rises. The returned line is sampled when the same clock falls, within the same period. The rising edge lasts a programmable number of system cycles before the fall. Lowering that number moves the sample closer to the update. A test can reduce the setting step by step until sent and received states first disagree. That point shows how much settling time the external path needs.

The step period is a parameter counted in system cycles. The default is 100000 cycles, which at 200 MHz gives a 0.5 ms step, or a 2 kHz update rate. Software fills a pattern memory and sets the run length. Pauses are written as runs of low states; a 200 ms gap at the default rate is 400 low states. Software then pulses `start`. The block reads one bit per step through a read port with a fixed latency of one cycle. The port has no stall, so the memory must always answer on the next cycle. No valid/ready handshake applies. `rx_in` must be synchronous to `clk`. Any synchronizer belongs outside the block, and its delay adds to the measured settle time.

Top module: `lbk_checker`

## Requirements
- R1: While reset is held and afterwards until a run starts, `tx_out`, `tclk_out`, `busy`, `done`, `mem_rd`, `mism_cnt`, `first_idx` and `first_vld` are all 0.
- R2: A start is taken when `start` is 1 in idle with a nonzero `run_len`. Pattern bit k then drives `tx_out` from the clock edge STEP_CYC*k+3 cycles after the start edge, for exactly STEP_CYC cycles.
- R3: `tclk_out` rises together with each new `tx_out` state and stays high for the clamped duty value H cycles. It stays low for the rest of the step.
- R4: The duty value `duty_hi` is latched at start and clamped into the range [1, STEP_CYC-1]. A value of 0 acts as 1. A value above STEP_CYC-1 acts as STEP_CYC-1.
- R5: `rx_in` is sampled at the clock edge where `tclk_out` falls, which is H cycles after the update. It is compared with the bit driven in that same step. Each disagreement adds one to `mism_cnt`.
- R6: On the first disagreement of a run, `first_vld` goes to 1 and `first_idx` holds that step's index. Later disagreements leave both unchanged.
- R7: At the edge ending the last step, `done` pulses for one cycle, `busy` falls and `tx_out` returns to 0. If the sample of the last step falls on that same edge, it is still counted.
- R8: A `start` pulse while `busy` is 1 has no effect. So does a `start` with `run_len` equal to 0.
- R9: `mism_cnt`, `first_idx` and `first_vld` hold their values after a run. They are cleared to 0 at the next accepted start.
- R10: The read port asserts `mem_rd` for exactly one cycle per bit, with `mem_addr` = k. Address 0 is read at the start edge, and address k+1 at the edge that drives bit k. `mem_rdata` must return the bit on the cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, taken in idle only |
| run_len | input | IDX_W | Number of pattern states in the run |
| duty_hi | input | CW | High time of the timing clock in system cycles |
| mem_rd | output | 1 | Pattern memory read strobe |
| mem_addr | output | IDX_W | Pattern memory read address |
| mem_rdata | input | 1 | Pattern bit, valid the cycle after `mem_rd` |
| rx_in | input | 1 | Returned signal from the external path |
| tx_out | output | 1 | Driven pattern line |
| tclk_out | output | 1 | Timing clock: rise is update, fall is sample |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle strobe at the end of a run |
| mism_cnt | output | IDX_W | Number of mismatched samples in the run |
| first_idx | output | IDX_W | Step index of the first mismatch |
| first_vld | output | 1 | A mismatch has occurred in the run |

## Verification
Two events can share one clock edge: the sample of the final step and the end of the run. This happens when the duty value is clamped to STEP_CYC-1. On that edge the comparison must use the last driven bit, while `tx_out` drops and `done` pulses. The bench provokes this with an oversized duty value and a returned line inverted only during the last step. It expects exactly one mismatch, recorded at the last index, on the same cycle as the done strobe. A delayed loopback with the duty set just below and just at the path delay shows that the fall edge samples at the intended cycle.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } lbk_state_e;
endpackage

// File: rtl/lbk_step_timer.sv
module lbk_step_timer #(
  parameter int STEP_CYC = 100000,
  parameter int CW       = $clog2(STEP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] duty_raw,
  input  logic          en,
  output logic          apply,
  output logic          sample,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cyc_q;
  logic [CW-1:0] hi_q;
  logic [CW-1:0] hi_d;

  // keep both phases at least one system cycle long
  always_comb begin
    if (duty_raw == '0)       hi_d = ONE;
    else if (duty_raw > LAST) hi_d = LAST;
    else                      hi_d = duty_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_q <= ONE;
    else if (load) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cyc_q <= '0;
    else if (!en)           cyc_q <= '0;
    else if (cyc_q == LAST) cyc_q <= '0;
    else                    cyc_q <= cyc_q + ONE;
  end

  assign apply  = en && (cyc_q == '0);
  assign sample = en && (cyc_q == hi_q);
  assign wrap   = en && (cyc_q == LAST);

  // R4: a clamped duty gives exactly one sample edge per step
  a_r4_sample_once: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample);
endmodule

// File: rtl/lbk_pattern_fetch.sv
module lbk_pattern_fetch #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [IDX_W-1:0] req_addr,
  output logic             mem_rd,
  output logic [IDX_W-1:0] mem_addr,
  input  logic             mem_rdata,
  output logic             arrive,
  output logic             bit_q
);
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      rd_q     <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      mem_rd <= req;
      if (req) mem_addr <= req_addr;
      rd_q <= mem_rd;
      if (rd_q) bit_q <= mem_rdata;
    end
  end

  assign arrive = rd_q;

  // R10: one read strobe per requested bit
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

// File: rtl/lbk_compare.sv
module lbk_compare #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] cnt,
  output logic [IDX_W-1:0] first_idx,
  output logic             first_vld
);
  logic miss;
  assign miss = sample && (tx_bit != rx_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      first_idx <= '0;
      first_vld <= 1'b0;
    end else if (clear) begin
      cnt       <= '0;
      first_idx <= '0;
      first_vld <= 1'b0;
    end else if (miss) begin
      cnt <= cnt + IDX_W'(1);
      if (!first_vld) begin
        first_vld <= 1'b1;
        first_idx <= idx;
      end
    end
  end

  // R5: at most one mismatch per cycle
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt == $past(cnt) || cnt == $past(cnt) + IDX_W'(1)));
  // R6: first mismatch index is kept
  a_r6_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (first_vld && !clear) |=> (first_vld && $stable(first_idx)));
endmodule

// File: rtl/lbk_checker.sv
module lbk_checker
  import lbk_pkg::*;
#(
  parameter int STEP_CYC = 100000,
  parameter int IDX_W    = 16,
  parameter int CW       = $clog2(STEP_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] run_len,
  input  logic [CW-1:0]    duty_hi,
  output logic             mem_rd,
  output logic [IDX_W-1:0] mem_addr,
  input  logic             mem_rdata,
  input  logic             rx_in,
  output logic             tx_out,
  output logic             tclk_out,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] mism_cnt,
  output logic [IDX_W-1:0] first_idx,
  output logic             first_vld
);
  initial begin
    if (STEP_CYC < 4) $error("STEP_CYC must be at least 4");
  end

  lbk_state_e       state_q;
  logic [IDX_W-1:0] len_q;
  logic [IDX_W-1:0] idx_q;
  logic             start_acc;
  logic             last_step;
  logic             apply, sample, wrap;
  logic             arrive, nxt_bit;
  logic             req;
  logic [IDX_W-1:0] req_addr;
  logic             run_en;

  assign start_acc = (state_q == ST_IDLE) && start && (run_len != '0);
  assign last_step = (idx_q == len_q - IDX_W'(1));
  assign run_en    = (state_q == ST_RUN);
  assign req       = start_acc || (apply && !last_step);
  assign req_addr  = start_acc ? '0 : idx_q + IDX_W'(1);
  assign busy      = (state_q != ST_IDLE);

  lbk_step_timer #(.STEP_CYC(STEP_CYC), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .duty_raw(duty_hi),
    .en(run_en), .apply(apply), .sample(sample), .wrap(wrap)
  );

  lbk_pattern_fetch #(.IDX_W(IDX_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .arrive(arrive), .bit_q(nxt_bit)
  );

  lbk_compare #(.IDX_W(IDX_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .sample(sample),
    .tx_bit(tx_out), .rx_bit(rx_in), .idx(idx_q),
    .cnt(mism_cnt), .first_idx(first_idx), .first_vld(first_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q <= ST_PRIME;
          len_q   <= run_len;
          idx_q   <= '0;
        end
        ST_PRIME: if (arrive) state_q <= ST_RUN;
        ST_RUN: if (wrap) begin
          if (last_step) state_q <= ST_IDLE;
          else           idx_q   <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_out   <= 1'b0;
      tclk_out <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= wrap && last_step;
      if (apply)                  tx_out <= nxt_bit;
      else if (wrap && last_step) tx_out <= 1'b0;
      if (apply)       tclk_out <= 1'b1;
      else if (sample) tclk_out <= 1'b0;
    end
  end

  // R7: completion strobe lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: outside a run both driven lines rest low
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_out && !tclk_out));
endmodule

// File: tb/test_lbk_checker.sv
module test_lbk_checker;
  localparam int S  = 8;
  localparam int IW = 6;
  localparam int CW = $clog2(S + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] run_len = '0;
  logic [CW-1:0] duty_hi = '0;
  logic          mem_rd;
  logic [IW-1:0] mem_addr;
  logic          mem_rdata = 1'b0;
  logic          rx_in = 1'b0;
  logic          tx_out, tclk_out, busy, done, first_vld;
  logic [IW-1:0] mism_cnt, first_idx;

  lbk_checker #(.STEP_CYC(S), .IDX_W(IW)) i_lbk_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .duty_hi(duty_hi), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rx_in(rx_in), .tx_out(tx_out),
    .tclk_out(tclk_out), .busy(busy), .done(done), .mism_cnt(mism_cnt),
    .first_idx(first_idx), .first_vld(first_vld)
  );

  bit pat [0:63];
  always @(posedge clk) if (mem_rd) mem_rdata <= pat[mem_addr];

  // values seen by the design at each rising edge
  logic          rst_e = 1'b0, st_e = 1'b0, rx_e = 1'b0;
  logic [IW-1:0] len_e = '0;
  logic [CW-1:0] duty_e = '0;
  always @(posedge clk) begin
    rst_e <= rst_n; st_e <= start; rx_e <= rx_in;
    len_e <= run_len; duty_e <= duty_hi;
  end

  int vec = 0, bad = 0;
  int m_e, m_len, m_hi, m_addr, m_cnt, m_first, m_step;
  bit m_act, m_tx, m_tclk, m_done, m_rd, m_fv;
  bit hist [0:7];
  int dly = 0, flip_k = -1;

  function automatic int clampd(int d);
    if (d == 0) return 1;
    if (d > S - 1) return S - 1;
    return d;
  endfunction

  task automatic chk(string req, string nm, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_act = 0; m_e = 0; m_len = 0; m_hi = 1; m_tx = 0; m_tclk = 0;
    m_done = 0; m_rd = 0; m_addr = 0; m_cnt = 0; m_first = 0; m_fv = 0; m_step = -1;
  endtask

  initial model_reset();

  always @(negedge clk) begin
    if (!rst_e) model_reset();
    else begin
      m_done = 0; m_rd = 0;
      if (m_act) begin
        int a;
        m_e++;
        a = m_e - 3;
        if (a >= 0) begin
          int k, c;
          k = a / S; c = a % S;
          if (c == 0) begin
            m_tx = pat[k]; m_tclk = 1; m_step = k;
            if (k < m_len - 1) begin m_rd = 1; m_addr = k + 1; end
          end
          if (c == m_hi) begin
            m_tclk = 0;
            if (rx_e != m_tx) begin
              m_cnt++;
              if (!m_fv) begin m_fv = 1; m_first = k; end
            end
          end
          if (c == S - 1 && k == m_len - 1) begin
            m_tx = 0; m_done = 1; m_act = 0; m_step = -1;
          end
        end
      end else if (st_e && len_e != 0) begin
        m_act = 1; m_e = 0; m_len = len_e; m_hi = clampd(int'(duty_e));
        m_cnt = 0; m_fv = 0; m_first = 0; m_rd = 1; m_addr = 0;
      end
    end
    // per-cycle comparison against the reference model
    chk("R2", "tx_out", tx_out, m_tx);
    chk("R3", "tclk_out", tclk_out, m_tclk);
    chk("R7", "done", done, m_done);
    chk("R8", "busy", busy, m_act);
    chk("R10", "mem_rd", mem_rd, m_rd);
    if (m_rd) chk("R10", "mem_addr", int'(mem_addr), m_addr);
    chk("R5", "mism_cnt", int'(mism_cnt), m_cnt);
    chk("R6", "first_vld", first_vld, m_fv);
    chk("R6", "first_idx", int'(first_idx), m_first);
    // returned line: model output through a delay, optional inversion
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = m_tx;
    rx_in <= hist[dly] ^ (m_step >= 0 && m_step == flip_k);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic run(int len, int duty, int d, int fk, int poke);
    dly = d; flip_k = fk;
    run_len = IW'(len); duty_hi = CW'(duty); start = 1'b1;
    tick(1);
    start = 1'b0;
    if (poke > 0) begin
      tick(poke);
      run_len = IW'(3); duty_hi = CW'(2); start = 1'b1;   // R8 restart while busy
      tick(1);
      start = 1'b0;
    end
    while (m_act) tick(1);
    tick(4);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) pat[i] = (i % 3 == 1) || (i % 7 == 0);
    tick(3);
    chk("R1", "reset tx_out", tx_out, 0);
    chk("R1", "reset mism_cnt", int'(mism_cnt), 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "idle busy", busy, 0);

    run(10, 6, 0, -1, 0);
    chk("R5", "clean loopback count", int'(mism_cnt), 0);
    run(10, 6, 0, 4, 0);
    chk("R6", "flip index", int'(first_idx), 4);
    tick(10);
    chk("R9", "count held after run", int'(mism_cnt), 1);
    run(12, 3, 3, -1, 0);
    chk("R5", "duty below delay misses", first_vld, 1);
    run(12, 4, 3, -1, 0);
    chk("R9", "cleared and settle ok", int'(mism_cnt), 0);
    run(6, 0, 0, -1, 0);
    chk("R4", "duty zero acts as one", int'(mism_cnt), 0);
    run(6, 15, 0, 5, 0);
    chk("R7", "last-step sample on final edge", int'(mism_cnt), 1);
    chk("R4", "clamped high index", int'(first_idx), 5);
    run(1, 5, 0, 0, 0);
    chk("R2", "single state run", int'(first_idx), 0);
    run(9, 5, 0, -1, 20);
    chk("R8", "restart ignored count", int'(mism_cnt), 0);
    run_len = '0; start = 1'b1;
    tick(1);
    start = 1'b0;
    tick(5);
    chk("R8", "zero length ignored", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule